// File: doc/BRIEF.md
# Multi-Word Command Register Sequencer

This block sits behind a host register port and turns register writes into complete commands. The host writes an opcode to the command register, then writes zero or more 32-bit payload words to the command-data register. The sequencer stores the payload in a word buffer. Each opcode needs a fixed number of payload words. When that many words have arrived, the sequencer pulses a start strobe to an external handler and presents the opcode, the word count and the buffer contents. When the handler pulses done with a result word, the sequencer copies that word into a command-status register, which the host can read at any time.

An opcode outside the legal range is replaced by an internal "unknown" command. That command needs no payload and finishes without calling the handler; it reports the failed code. The same happens to a data word written when no command is open. From an opcode write until the command finishes, the status register shows a "not enough data" code. While a handler is busy, the register port holds off further writes by dropping its ready signal.

The controller has three states:
- `S_COLLECT`: accepts writes.
- `S_DISPATCH`: lasts one cycle. It either pulses start, or finishes the unknown command.
- `S_WAIT`: waits for the handler's done pulse.

The transitions are:
- `S_COLLECT` to `S_DISPATCH` on a write that completes the payload.
- `S_COLLECT` stays in `S_COLLECT` on any other write, or when there is no write.
- `S_DISPATCH` to `S_WAIT` when a real opcode is open.
- `S_DISPATCH` to `S_COLLECT` for the unknown command.
- `S_WAIT` to `S_COLLECT` on done.

Top module: `cmd_sequencer`

## Requirements
- R1: After reset, `cmd_status` is 0 (succeeded), `wr_ready` is 1, `hdl_start` is 0, and the open command is the unknown command.
- R2: An opcode write is accepted as a real command only if its full 32-bit value is strictly greater than 0 and strictly less than 10. Any other value selects the unknown command. The unknown command never pulses `hdl_start`. Two cycles after the write, `cmd_status` reads 0xFFFFFFFF (failed).
- R3: An opcode write clears the word counter and sets `cmd_status` to 0xFFFFFFFE (not enough data). The status keeps that value until the command completes. A new opcode written in the middle of a payload discards the earlier words, and counting starts again from zero.
- R4: Each opcode needs a fixed number of payload words:
  - 1 (configure): 6 words.
  - 2 (issue) and 3 (unplug): 0 words.
  - 4 (set up rings): `RINGS_WORDS` words, default 10.
  - 5 (device reset): `DEVRST_WORDS` words, default 3.
  - 6 (bus reset) and 8 (adapter reset): 0 words.
  - 7 (message ring set-up): `MSGRING_WORDS` words, default 5.
  - 9 (abort): `ABORT_WORDS` words, default 4.

  `hdl_start` is high in the cycle after the write that completes the payload. For a zero-word opcode, that write is the opcode write itself.
- R5: Word k of the payload (k counted from 0) appears at `hdl_words[32k+31:32k]`. During the start cycle, `hdl_opcode` carries the opcode and `hdl_count` carries the number of payload words.
- R6: On a cycle in `S_WAIT` with `hdl_done` high, the value on `hdl_result` becomes `cmd_status` in the following cycle. The open command then reverts to the unknown command with the counter cleared.
- R7: From the start cycle until the cycle after done, `wr_ready` is 0, and any write held on the port in that time is not taken.
- R8: A data write made while no command is open completes the unknown command. It does not start the handler, and `cmd_status` becomes 0xFFFFFFFF.
- R9: The word counter never exceeds the buffer depth. The depth is the largest per-opcode word count, and no write lands beyond the buffer.
- R10: `hdl_start` lasts exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host register write request |
| wr_ready | output | 1 | Write accepted this cycle when high together with wr_valid |
| wr_sel | input | 1 | 0 = command (opcode) register, 1 = command-data register |
| wr_data | input | 32 | Write value |
| hdl_start | output | 1 | One-cycle handler start strobe |
| hdl_opcode | output | 4 | Opcode of the command being handed over |
| hdl_count | output | CNT_W (4) | Number of payload words collected |
| hdl_words | output | DEPTH*32 (320) | Payload buffer, word 0 in the low bits |
| hdl_done | input | 1 | Handler finished, result valid |
| hdl_result | input | 32 | Handler result word |
| cmd_status | output | 32 | Command-status register read-back |

## Verification
The hardest case to reach from the ports is a command interrupted part-way: an earlier payload is abandoned by a fresh opcode, or by reset. The stimulus therefore writes a partial set-up payload and then overwrites it with an abort opcode whose words use a different pattern. It checks that the handler sees only the new words and the count for the new opcode. A second sequence resets the block in the middle of a payload and then writes a stray data word, which shows that the open command fell back to the unknown command. Backpressure is reached by holding a write on the port across the dispatch and wait cycles, then checking that it was never taken.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int WORD_W = 32;
    localparam int OPW    = 4;

    typedef logic [OPW-1:0] cmd_code_t;

    // Opcode values decoded by the handler side.
    localparam cmd_code_t OP_NONE    = 4'd0;
    localparam cmd_code_t OP_CONFIG  = 4'd1;
    localparam cmd_code_t OP_ISSUE   = 4'd2;
    localparam cmd_code_t OP_UNPLUG  = 4'd3;
    localparam cmd_code_t OP_RINGS   = 4'd4;
    localparam cmd_code_t OP_DEVRST  = 4'd5;
    localparam cmd_code_t OP_BUSRST  = 4'd6;
    localparam cmd_code_t OP_MSGRING = 4'd7;
    localparam cmd_code_t OP_ADPRST  = 4'd8;
    localparam cmd_code_t OP_ABORT   = 4'd9;
    localparam int        OP_LIMIT   = 10;

    localparam logic [WORD_W-1:0] STAT_OK    = 32'h0000_0000;
    localparam logic [WORD_W-1:0] STAT_FAIL  = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] STAT_SHORT = 32'hFFFF_FFFE;

    typedef enum logic [1:0] {
        S_COLLECT  = 2'd0,
        S_DISPATCH = 2'd1,
        S_WAIT     = 2'd2
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import cmdseq_pkg::*;
(
    input  logic [WORD_W-1:0] raw_i,
    output cmd_code_t         op_o
);
    logic in_range;

    always_comb begin
        in_range = (raw_i != '0) && (raw_i < WORD_W'(OP_LIMIT));
        op_o     = in_range ? raw_i[OPW-1:0] : OP_NONE;
    end
endmodule

// File: rtl/cmd_need.sv
module cmd_need
    import cmdseq_pkg::*;
#(
    parameter int CONFIG_WORDS  = 6,
    parameter int RINGS_WORDS   = 10,
    parameter int DEVRST_WORDS  = 3,
    parameter int MSGRING_WORDS = 5,
    parameter int ABORT_WORDS   = 4,
    parameter int CNT_W         = 4
) (
    input  cmd_code_t        op_i,
    output logic [CNT_W-1:0] words_o
);
    always_comb begin
        unique case (op_i)
            OP_CONFIG:  words_o = CNT_W'(CONFIG_WORDS);
            OP_RINGS:   words_o = CNT_W'(RINGS_WORDS);
            OP_DEVRST:  words_o = CNT_W'(DEVRST_WORDS);
            OP_MSGRING: words_o = CNT_W'(MSGRING_WORDS);
            OP_ABORT:   words_o = CNT_W'(ABORT_WORDS);
            default:    words_o = '0;
        endcase
    end
endmodule

// File: rtl/cmd_wordbuf.sv
module cmd_wordbuf
    import cmdseq_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int CNT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [CNT_W-1:0]        idx_i,
    input  logic [WORD_W-1:0]       wdata_i,
    output logic [DEPTH*WORD_W-1:0] words_o
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (we_i && (idx_i == CNT_W'(g))) begin
                slot_q <= wdata_i;
            end
        end
        assign words_o[g*WORD_W +: WORD_W] = slot_q;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (idx_i < CNT_W'(DEPTH))); // R9
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
    import cmdseq_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic              wr_sel_i,
    input  cmd_code_t         new_op_i,
    input  logic [CNT_W-1:0]  new_need_i,
    input  logic [CNT_W-1:0]  cur_need_i,
    input  logic              done_i,
    input  logic [WORD_W-1:0] result_i,
    output logic              wr_ready_o,
    output logic              buf_we_o,
    output cmd_code_t         cur_op_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              start_o,
    output logic [WORD_W-1:0] status_o
);
    seq_state_t        state_q, state_d;
    cmd_code_t         cur_op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic [WORD_W-1:0] status_q;
    logic              wr_fire;

    assign wr_fire = wr_valid_i && (state_q == S_COLLECT);
    assign cnt_inc = cnt_q + CNT_W'(1);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_COLLECT: begin
                if (wr_fire) begin
                    if (!wr_sel_i) begin
                        if (new_need_i == '0) state_d = S_DISPATCH;
                    end else if (cnt_inc >= cur_need_i) begin
                        state_d = S_DISPATCH;
                    end
                end
            end
            S_DISPATCH: state_d = (cur_op_q == OP_NONE) ? S_COLLECT : S_WAIT;
            S_WAIT:     if (done_i) state_d = S_COLLECT;
            default:    state_d = S_COLLECT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_COLLECT;
        else        state_q <= state_d;
    end

    // Command, counter and status registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_op_q <= OP_NONE;
            cnt_q    <= '0;
            status_q <= STAT_OK;
        end else begin
            unique case (state_q)
                S_COLLECT: begin
                    if (wr_fire) begin
                        if (!wr_sel_i) begin
                            cur_op_q <= new_op_i;
                            cnt_q    <= '0;
                            status_q <= STAT_SHORT;
                        end else begin
                            cnt_q <= cnt_inc;
                        end
                    end
                end
                S_DISPATCH: begin
                    if (cur_op_q == OP_NONE) begin
                        status_q <= STAT_FAIL;
                        cnt_q    <= '0;
                    end
                end
                S_WAIT: begin
                    if (done_i) begin
                        status_q <= result_i;
                        cur_op_q <= OP_NONE;
                        cnt_q    <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        wr_ready_o = (state_q == S_COLLECT);
        buf_we_o   = wr_fire && wr_sel_i;
        start_o    = (state_q == S_DISPATCH) && (cur_op_q != OP_NONE);
        cur_op_o   = cur_op_q;
        cnt_o      = cnt_q;
        status_o   = status_q;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R9
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R10
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !wr_ready_o); // R7
    AST_OPCODE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_ready_o && !wr_sel_i) |=> (status_o == STAT_SHORT)); // R3
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready_o && !wr_valid_i) |=> $stable(status_o)); // R3
    AST_DONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && done_i) |=> (status_o == $past(result_i))); // R6
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !done_i) |=> $stable(cur_op_o)); // R10
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
    import cmdseq_pkg::*;
#(
    parameter int CONFIG_WORDS  = 6,
    parameter int RINGS_WORDS   = 10,
    parameter int DEVRST_WORDS  = 3,
    parameter int MSGRING_WORDS = 5,
    parameter int ABORT_WORDS   = 4,
    localparam int DEPTH = imax(imax(imax(CONFIG_WORDS, RINGS_WORDS),
                                     imax(DEVRST_WORDS, MSGRING_WORDS)),
                                imax(ABORT_WORDS, 1)),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic                    wr_sel,
    input  logic [31:0]             wr_data,
    output logic                    hdl_start,
    output logic [3:0]              hdl_opcode,
    output logic [CNT_W-1:0]        hdl_count,
    output logic [DEPTH*32-1:0]     hdl_words,
    input  logic                    hdl_done,
    input  logic [31:0]             hdl_result,
    output logic [31:0]             cmd_status
);
    cmd_code_t        new_op;
    cmd_code_t        cur_op;
    logic [CNT_W-1:0] new_need;
    logic [CNT_W-1:0] cur_need;
    logic [CNT_W-1:0] cnt;
    logic             buf_we;

    cmd_decode u_decode (
        .raw_i (wr_data),
        .op_o  (new_op)
    );

    cmd_need #(
        .CONFIG_WORDS (CONFIG_WORDS),
        .RINGS_WORDS  (RINGS_WORDS),
        .DEVRST_WORDS (DEVRST_WORDS),
        .MSGRING_WORDS(MSGRING_WORDS),
        .ABORT_WORDS  (ABORT_WORDS),
        .CNT_W        (CNT_W)
    ) u_need_new (
        .op_i    (new_op),
        .words_o (new_need)
    );

    cmd_need #(
        .CONFIG_WORDS (CONFIG_WORDS),
        .RINGS_WORDS  (RINGS_WORDS),
        .DEVRST_WORDS (DEVRST_WORDS),
        .MSGRING_WORDS(MSGRING_WORDS),
        .ABORT_WORDS  (ABORT_WORDS),
        .CNT_W        (CNT_W)
    ) u_need_cur (
        .op_i    (cur_op),
        .words_o (cur_need)
    );

    cmd_fsm #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid),
        .wr_sel_i   (wr_sel),
        .new_op_i   (new_op),
        .new_need_i (new_need),
        .cur_need_i (cur_need),
        .done_i     (hdl_done),
        .result_i   (hdl_result),
        .wr_ready_o (wr_ready),
        .buf_we_o   (buf_we),
        .cur_op_o   (cur_op),
        .cnt_o      (cnt),
        .start_o    (hdl_start),
        .status_o   (cmd_status)
    );

    cmd_wordbuf #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (buf_we),
        .idx_i   (cnt),
        .wdata_i (wr_data),
        .words_o (hdl_words)
    );

    assign hdl_opcode = cur_op;
    assign hdl_count  = cnt;
endmodule

// File: tb/sim_cmd_sequencer.sv
module sim_cmd_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 10;
    localparam int CNT_W      = 4;
    localparam int NVEC       = 12;
    localparam logic [31:0] K_OK    = 32'h0;
    localparam logic [31:0] K_FAIL  = 32'hFFFF_FFFF;
    localparam logic [31:0] K_SHORT = 32'hFFFF_FFFE;

    // Vector table: opcode, payload words, handler result.
    localparam logic [31:0] V_OP [NVEC] = '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6,
                                            32'd7, 32'd8, 32'd9, 32'd0, 32'd10, 32'hFFFF_FFFF};
    localparam int          V_NW [NVEC] = '{6, 0, 0, 10, 3, 0, 5, 0, 4, 0, 0, 0};
    localparam logic [31:0] V_RES[NVEC] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                            32'h0, 32'h0, 32'h0, 32'h5, 32'h0, 32'h0,
                                            32'h0, 32'h0, 32'h0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic              wr_sel = 1'b0;
    logic [31:0]       wr_data = '0;
    logic              hdl_start;
    logic [3:0]        hdl_opcode;
    logic [CNT_W-1:0]  hdl_count;
    logic [DEPTH*32-1:0] hdl_words;
    logic              hdl_done = 1'b0;
    logic [31:0]       hdl_result = '0;
    logic [31:0]       cmd_status;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_sel(wr_sel), .wr_data(wr_data), .hdl_start(hdl_start),
        .hdl_opcode(hdl_opcode), .hdl_count(hdl_count), .hdl_words(hdl_words),
        .hdl_done(hdl_done), .hdl_result(hdl_result), .cmd_status(cmd_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic finish_handler(input logic [31:0] res);
        @(negedge clk);
        chk("R7 ready low while busy", {31'd0, wr_ready}, 32'd0);
        chk("R10 start single cycle", {31'd0, hdl_start}, 32'd0);
        hdl_done = 1'b1; hdl_result = res;
        @(negedge clk);
        hdl_done = 1'b0;
        chk("R6 result to status", cmd_status, res);
        chk("R7 ready back", {31'd0, wr_ready}, 32'd1);
    endtask

    task automatic run_cmd(input logic [31:0] op, input int nw,
                           input logic [31:0] res, input logic [31:0] base);
        logic real_op;
        real_op = (op != 0) && (op < 10);
        wr(1'b0, op);
        for (int i = 0; i < nw; i++) begin
            chk("R3 pending before complete", cmd_status, K_SHORT);
            wr(1'b1, base + 32'(i));
        end
        if (real_op) begin
            chk("R4 start after last write", {31'd0, hdl_start}, 32'd1);
            chk("R5 opcode", {28'd0, hdl_opcode}, op);
            chk("R5 count", 32'(hdl_count), 32'(nw));
            for (int i = 0; i < nw; i++)
                chk("R5 word order", hdl_words[i*32 +: 32], base + 32'(i));
            finish_handler(res);
        end else begin
            chk("R2 no start for unknown", {31'd0, hdl_start}, 32'd0);
            @(negedge clk);
            chk("R2 unknown fails", cmd_status, K_FAIL);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", cmd_status, K_OK);
        chk("R1 reset ready", {31'd0, wr_ready}, 32'd1);
        chk("R1 reset start", {31'd0, hdl_start}, 32'd0);

        // Table walk: R2 R4 R5 R6.
        for (int v = 0; v < NVEC; v++)
            run_cmd(V_OP[v], V_NW[v], V_RES[v], 32'hA000_0000 + 32'(v << 8));

        // R8: stray data word with no open command.
        wr(1'b1, 32'h1234_5678);
        chk("R8 stray no start", {31'd0, hdl_start}, 32'd0);
        @(negedge clk);
        chk("R8 stray fails", cmd_status, K_FAIL);

        // R6: after completion the command reverts; next data write fails.
        run_cmd(32'd5, 3, 32'h0000_00AA, 32'hB000_0000);
        wr(1'b1, 32'h1);
        @(negedge clk);
        chk("R6 reverted to unknown", cmd_status, K_FAIL);

        // R3: opcode rewrite mid-payload restarts counting.
        wr(1'b0, 32'd4);
        for (int i = 0; i < 3; i++) wr(1'b1, 32'hC000_0000 + 32'(i));
        chk("R3 still pending", cmd_status, K_SHORT);
        run_cmd(32'd9, 4, 32'h0000_0077, 32'hD000_0000);

        // R7: write held across busy window is not taken.
        wr(1'b0, 32'd1);
        for (int i = 0; i < 6; i++) wr(1'b1, 32'hE000_0000 + 32'(i));
        chk("R4 config start", {31'd0, hdl_start}, 32'd1);
        wr_valid = 1'b1; wr_sel = 1'b0; wr_data = 32'd6;
        @(negedge clk);
        chk("R7 held write blocked", {31'd0, wr_ready}, 32'd0);
        chk("R7 status untouched", cmd_status, K_SHORT);
        @(negedge clk);
        chk("R7 still pending", cmd_status, K_SHORT);
        wr_valid = 1'b0;
        hdl_done = 1'b1; hdl_result = 32'h0000_0BAD;
        @(negedge clk);
        hdl_done = 1'b0;
        chk("R6 config result", cmd_status, 32'h0000_0BAD);
        @(negedge clk);
        chk("R7 no late acceptance", {31'd0, hdl_start}, 32'd0);
        chk("R7 status kept", cmd_status, 32'h0000_0BAD);

        // R1: reset mid-payload.
        wr(1'b0, 32'd4);
        wr(1'b1, 32'h11);
        wr(1'b1, 32'h22);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset mid status", cmd_status, K_OK);
        chk("R1 reset mid ready", {31'd0, wr_ready}, 32'd1);
        wr(1'b1, 32'h33);
        chk("R1 no start after reset", {31'd0, hdl_start}, 32'd0);
        @(negedge clk);
        chk("R1 command unknown after reset", cmd_status, K_FAIL);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule